// File: doc/BRIEF.md
# Configuration Port Block Transfer Engine

This peripheral sits between a simple memory-mapped bus and a 32-bit configuration port. Software fills a 2048-byte staging buffer through the bus. It then programs a transfer length in bytes and a starting word index. A single write to a launch register then chooses the direction and starts an autonomous block move. In configure mode the engine streams buffer words out to the port. In readback mode it captures port words into the buffer.

A status word reports completion. The same word carries four live flags from the port next to a group of fixed one bits. A write to the status location aborts a running move. Requests that would run past the end of the buffer finish at once without touching the port. While a move runs, the engine owns the buffer's single port.

Top module: `cfg_xfer_engine`

## Requirements
- R1: The buffer is visible at bus byte addresses below 0x800, with word N at byte address 4*N. A bus write stores the word. A bus read returns it on `bus_rdata` one clock after the request cycle.
- R2: The length register (0x800, bytes) and the start-index register (0x804, word index) read back the last value written to them.
- R3: A read of status (0x80C) returns bit 0 = done, bits 4:1 = 1111, bit 8 = `cp_flags[3]` (configuration error), bit 7 = `cp_flags[2]` (data aligned), bit 6 = `cp_flags[1]` (readback in progress), bit 5 = `cp_flags[0]` (abort-in, active low), and zeros above.
- R4: After reset, done reads 1 and `cp_en` is low.
- R5: A write of 0 to the launch register (0x808) drives buffer words start..start+length/4-1 in ascending order on `cp_data_out` with `cp_en`=1 and `cp_rd`=0. A word advances only in a cycle where `cp_ready` is 1, and it is held while `cp_ready` is 0.
- R6: A write of 1 to the launch register samples `cp_data_in` in each cycle where `cp_en`, `cp_rd` and `cp_ready` are all 1. The samples are stored in consecutive buffer words, starting at the start index.
- R7: Done reads 0 from the cycle after a launch write. It returns to 1 once the last word has moved.
- R8: A launch write while done is 0 is ignored.
- R9: A launch where start index plus length/4 exceeds 512, or where length/4 is zero, asserts no `cp_en` and completes with done = 1 two cycles after the write.
- R10: A bus write of any value to status aborts the running move: `cp_en` drops and done reads 1.
- R11: Bus writes to the buffer while done is 0 leave the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_en | input | 1 | bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | byte address |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid one cycle after the request |
| cp_data_out | output | 32 | word to the configuration port |
| cp_en | output | 1 | port enable |
| cp_rd | output | 1 | 1 = readback, 0 = configure |
| cp_data_in | input | 32 | word from the configuration port |
| cp_ready | input | 1 | port accepts or supplies a word this cycle |
| cp_flags | input | 4 | {cfg error, data aligned, readback busy, abort-in low} |

## Verification
Every bus read result is due one clock after its request cycle. Each bench task issues the request just after a falling edge and samples at the next falling edge. A status read issued right after a launch is latched while the sequencer is still in its range-check cycle, so it must show done = 0. For an out-of-range request, that first read shows 0 and the following read shows 1. Port words are due in any cycle where the enable and `cp_ready` are both high. A monitor that runs on the falling edge pops an expected queue for those words, and it flags any word that arrives with the queue empty.

// File: rtl/cxe_pkg.sv
package cxe_pkg;
   // register select within the control window, from byte address bits 3:2
   typedef enum logic [1:0] {
      RG_LEN    = 2'd0,
      RG_START  = 2'd1,
      RG_LAUNCH = 2'd2,
      RG_STATUS = 2'd3
   } reg_sel_t;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_CHECK = 2'd1,
      SQ_FETCH = 2'd2,
      SQ_MOVE  = 2'd3
   } sq_state_t;

   localparam int FLAG_W    = 4;
   localparam int ONES_W    = 4;
   localparam int LAUNCH_RB = 1;
endpackage

// File: rtl/cxe_buffer.sv
module cxe_buffer #(
   parameter int WORDS  = 512,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [IDX_W-1:0]  addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [WORDS];

   // single port; read data registered and held until the next read
   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/cxe_regbank.sv
module cxe_regbank
   import cxe_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int WORDS  = 512,
   localparam int IDX_W  = $clog2(WORDS),
   localparam int ADDR_W = IDX_W + 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_en,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic                done,
   input  logic [FLAG_W-1:0]   flags,
   input  logic [DATA_W-1:0]   buf_rdata,
   output logic                b_en,
   output logic                b_we,
   output logic [IDX_W-1:0]    b_addr,
   output logic [DATA_W-1:0]   b_wdata,
   output logic [DATA_W-1:0]   len_q,
   output logic [DATA_W-1:0]   start_q,
   output logic                launch,
   output logic                launch_dir,
   output logic                abort
);
   localparam int STAT_W = 1 + ONES_W + FLAG_W;

   logic              in_win;
   reg_sel_t          rsel;
   logic              wr_hit, rd_hit;
   logic              rsel_reg_q;
   logic [DATA_W-1:0] reg_rd_q;
   logic [DATA_W-1:0] status_w;

   assign in_win = bus_addr[ADDR_W-1];
   assign rsel   = reg_sel_t'(bus_addr[3:2]);
   assign wr_hit = bus_en && bus_we && in_win;
   assign rd_hit = bus_en && !bus_we;

   assign b_en    = bus_en && !in_win;
   assign b_we    = bus_we;
   assign b_addr  = bus_addr[ADDR_W-2:2];
   assign b_wdata = bus_wdata;

   assign launch     = wr_hit && (rsel == RG_LAUNCH);
   assign launch_dir = bus_wdata[0] == 1'(LAUNCH_RB);
   assign abort      = wr_hit && (rsel == RG_STATUS);

   generate
      if (DATA_W > STAT_W) begin : g_pad
         assign status_w = {{(DATA_W-STAT_W){1'b0}}, flags, {ONES_W{1'b1}}, done};
      end else begin : g_nopad
         assign status_w = {flags, {ONES_W{1'b1}}, done};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q   <= '0;
         start_q <= '0;
      end else if (wr_hit) begin
         if (rsel == RG_LEN)   len_q   <= bus_wdata;
         if (rsel == RG_START) start_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsel_reg_q <= 1'b0;
         reg_rd_q   <= '0;
      end else if (rd_hit) begin
         rsel_reg_q <= in_win;
         unique case (rsel)
            RG_LEN:    reg_rd_q <= len_q;
            RG_START:  reg_rd_q <= start_q;
            RG_LAUNCH: reg_rd_q <= '0;
            RG_STATUS: reg_rd_q <= status_w;
         endcase
      end
   end

   assign bus_rdata = rsel_reg_q ? reg_rd_q : buf_rdata;

   assert_len_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && rsel == RG_LEN) |=> (len_q == $past(bus_wdata)));

   assert_status_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && in_win && rsel == RG_STATUS) |=> (bus_rdata[ONES_W:1] == {ONES_W{1'b1}}));
endmodule

// File: rtl/cxe_sequencer.sv
module cxe_sequencer
   import cxe_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int WORDS  = 512,
   localparam int IDX_W = $clog2(WORDS),
   localparam int CNT_W = IDX_W + 1,
   localparam int WIDE_W = DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              launch_dir,
   input  logic              abort,
   input  logic [DATA_W-1:0] len_q,
   input  logic [DATA_W-1:0] start_q,
   output logic              e_en,
   output logic              e_we,
   output logic [IDX_W-1:0]  e_addr,
   output logic [DATA_W-1:0] e_wdata,
   input  logic [DATA_W-1:0] buf_rdata,
   output logic [DATA_W-1:0] cp_data_out,
   output logic              cp_en,
   output logic              cp_rd,
   input  logic [DATA_W-1:0] cp_data_in,
   input  logic              cp_ready,
   output logic              done
);
   sq_state_t         state_q;
   logic              dir_q;
   logic [DATA_W-1:0] req_cnt_q;
   logic [DATA_W-1:0] req_off_q;
   logic [IDX_W-1:0]  ptr_q;
   logic [CNT_W-1:0]  rem_q;
   logic [WIDE_W-1:0] span;
   logic              in_range;
   logic              step;

   assign span     = {1'b0, req_off_q} + {1'b0, req_cnt_q};
   assign in_range = (span <= WIDE_W'(WORDS)) && (req_cnt_q != '0);
   assign done     = (state_q == SQ_IDLE);
   assign cp_en    = (state_q == SQ_MOVE);
   assign cp_rd    = dir_q;
   assign step     = cp_en && cp_ready;

   always_comb begin
      e_en        = 1'b0;
      e_we        = 1'b0;
      e_addr      = ptr_q;
      e_wdata     = cp_data_in;
      cp_data_out = '0;
      if (state_q == SQ_FETCH) begin
         e_en = 1'b1;
      end else if (state_q == SQ_MOVE) begin
         if (dir_q) begin
            e_en = cp_ready;
            e_we = 1'b1;
         end else begin
            cp_data_out = buf_rdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         dir_q     <= 1'b0;
         req_cnt_q <= '0;
         req_off_q <= '0;
         ptr_q     <= '0;
         rem_q     <= '0;
      end else if (abort) begin
         state_q <= SQ_IDLE;
      end else begin
         unique case (state_q)
            SQ_IDLE: if (launch) begin
               dir_q     <= launch_dir;
               req_cnt_q <= len_q >> 2;
               req_off_q <= start_q;
               state_q   <= SQ_CHECK;
            end
            SQ_CHECK: begin
               if (in_range) begin
                  ptr_q   <= req_off_q[IDX_W-1:0];
                  rem_q   <= req_cnt_q[CNT_W-1:0];
                  state_q <= dir_q ? SQ_MOVE : SQ_FETCH;
               end else begin
                  state_q <= SQ_IDLE;
               end
            end
            SQ_FETCH: state_q <= SQ_MOVE;
            SQ_MOVE: if (step) begin
               ptr_q <= ptr_q + 1'b1;
               rem_q <= rem_q - 1'b1;
               if (rem_q == CNT_W'(1)) state_q <= SQ_IDLE;
               else                    state_q <= dir_q ? SQ_MOVE : SQ_FETCH;
            end
         endcase
      end
   end

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cp_en);

   assert_hold_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_en && !cp_ready && !abort) |=> (cp_en && $stable(cp_data_out)));

   assert_launch_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && done && !abort) |=> !done);

   assert_busy_launch_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !done) |=> $stable(dir_q));

   assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_CHECK && !in_range && !abort) |=> (done && !cp_en));

   assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (done && !cp_en));
endmodule

// File: rtl/cfg_xfer_engine.sv
module cfg_xfer_engine
   import cxe_pkg::*;
#(
   parameter int BUF_BYTES = 2048,
   parameter int DATA_W    = 32,
   localparam int WORDS    = BUF_BYTES / 4,
   localparam int IDX_W    = $clog2(WORDS),
   localparam int ADDR_W   = IDX_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] cp_data_out,
   output logic              cp_en,
   output logic              cp_rd,
   input  logic [DATA_W-1:0] cp_data_in,
   input  logic              cp_ready,
   input  logic [FLAG_W-1:0] cp_flags
);
   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("cfg_xfer_engine: DATA_W must be 32");
      end
      if ((WORDS < 4) || ((1 << IDX_W) != WORDS) || (WORDS * 4 != BUF_BYTES)) begin : g_bad_depth
         $error("cfg_xfer_engine: BUF_BYTES must be a power of two of at least 16");
      end
   endgenerate

   logic              done;
   logic              b_en, b_we;
   logic [IDX_W-1:0]  b_addr;
   logic [DATA_W-1:0] b_wdata;
   logic              e_en, e_we;
   logic [IDX_W-1:0]  e_addr;
   logic [DATA_W-1:0] e_wdata;
   logic              m_en, m_we;
   logic [IDX_W-1:0]  m_addr;
   logic [DATA_W-1:0] m_wdata, m_rdata;
   logic [DATA_W-1:0] len_q, start_q;
   logic              launch, launch_dir, abort;

   cxe_regbank #(.DATA_W(DATA_W), .WORDS(WORDS)) i_regs (
      .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
      .done, .flags(cp_flags), .buf_rdata(m_rdata),
      .b_en, .b_we, .b_addr, .b_wdata,
      .len_q, .start_q, .launch, .launch_dir, .abort
   );

   cxe_sequencer #(.DATA_W(DATA_W), .WORDS(WORDS)) i_seq (
      .clk, .rst_n, .launch, .launch_dir, .abort, .len_q, .start_q,
      .e_en, .e_we, .e_addr, .e_wdata, .buf_rdata(m_rdata),
      .cp_data_out, .cp_en, .cp_rd, .cp_data_in, .cp_ready, .done
   );

   // engine owns the single buffer port whenever a move is in progress
   assign m_en    = done ? b_en    : e_en;
   assign m_we    = done ? b_we    : e_we;
   assign m_addr  = done ? b_addr  : e_addr;
   assign m_wdata = done ? b_wdata : e_wdata;

   cxe_buffer #(.WORDS(WORDS), .DATA_W(DATA_W)) i_buf (
      .clk, .en(m_en), .we(m_we), .addr(m_addr), .wdata(m_wdata), .rdata(m_rdata)
   );

   assert_busy_bus_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && m_en && m_we) |-> (cp_en && cp_rd && cp_ready));
endmodule

// File: tb/test_cfg_xfer_engine.sv
module test_cfg_xfer_engine;
   localparam logic [11:0] A_LEN = 12'h800, A_START = 12'h804,
                           A_LAUNCH = 12'h808, A_STATUS = 12'h80C;

   logic        clk = 0, rst_n = 0;
   logic        bus_en = 0, bus_we = 0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [31:0] cp_data_out, cp_data_in = '0;
   logic        cp_en, cp_rd, cp_ready = 0;
   logic [3:0]  cp_flags = 4'b1010;

   int errors = 0, checks = 0;
   int ready_mode = 0;
   int cap_idx = 0;
   bit prev_acc = 0;
   int en_cycles = 0;
   int cyc = 0;
   bit finished = 0;
   logic [31:0] exp_q[$];
   logic [31:0] mdl [512];

   always #2.5 clk = ~clk;

   cfg_xfer_engine i_cfg_xfer_engine (
      .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
      .cp_data_out, .cp_en, .cp_rd, .cp_data_in, .cp_ready, .cp_flags
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // port model and scoreboard monitor
   always @(negedge clk) begin
      cyc++;
      if (prev_acc) cap_idx++;
      cp_data_in = 32'hCAFE_0000 + cap_idx;
      cp_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? cyc[0] : 1'b0;
      prev_acc = cp_en && cp_rd && cp_ready;
      if (cp_en) en_cycles++;
      if (cp_en && !cp_rd && cp_ready) begin
         if (exp_q.size() == 0) check("R5 unexpected word", cp_data_out, 32'hxxxx_xxxx);
         else check("R5 port word", cp_data_out, exp_q.pop_front());
      end
   end

   task automatic bus_wr(logic [11:0] a, logic [31:0] d);
      bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 0; bus_we = 0;
   endtask

   task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
      bus_en = 1; bus_we = 0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_en = 0;
   endtask

   task automatic wait_done(string req);
      logic [31:0] s;
      for (int i = 0; i < 400; i++) begin
         bus_rd(A_STATUS, s);
         if (s[0]) break;
      end
      check(req, {31'd0, s[0]}, 32'd1);
   endtask

   // driver: fills the buffer and queues the words expected at the port
   task automatic configure(int off, int n, int rmode);
      logic [31:0] s;
      ready_mode = rmode;
      for (int i = 0; i < n; i++) exp_q.push_back(mdl[off+i]);
      bus_wr(A_LEN, n * 4);
      bus_wr(A_START, off);
      bus_wr(A_LAUNCH, 32'd0);
      bus_rd(A_STATUS, s);
      check("R7 done low after launch", {31'd0, s[0]}, 32'd0);
      wait_done("R7 done after last word");
      check("R5 all words delivered", exp_q.size(), 0);
   endtask

   initial begin
      logic [31:0] d;
      int en0, base;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R4 / R3 reset status and flag packing
      check("R4 cp_en low after reset", {31'd0, cp_en}, 32'd0);
      bus_rd(A_STATUS, d);
      check("R3 R4 status after reset", d, 32'h0000_015F);
      cp_flags = 4'b0101;
      bus_rd(A_STATUS, d);
      check("R3 status flags", d, 32'h0000_00BF);

      // R1 buffer access
      for (int i = 0; i < 512; i++) mdl[i] = 32'h1000_0000 + i * 32'h0001_0003;
      for (int i = 0; i < 16; i++) bus_wr(12'(i * 4), mdl[i]);
      for (int i = 500; i < 512; i++) bus_wr(12'(i * 4), mdl[i]);
      for (int i = 96; i < 110; i++) bus_wr(12'(i * 4), mdl[i]);
      bus_wr(12'(300 * 4), mdl[300]);
      bus_rd(12'h000, d);   check("R1 word 0", d, mdl[0]);
      bus_rd(12'h01C, d);   check("R1 word 7", d, mdl[7]);
      bus_rd(12'h7FC, d);   check("R1 word 511", d, mdl[511]);

      // R2 register readback
      bus_wr(A_LEN, 32'h0000_0040);
      bus_wr(A_START, 32'h0000_0003);
      bus_rd(A_LEN, d);     check("R2 length", d, 32'h0000_0040);
      bus_rd(A_START, d);   check("R2 start", d, 32'h0000_0003);

      // R5 R7 configure, ready always high
      configure(3, 8, 0);
      // R5 configure at the buffer end with gapped ready
      configure(504, 8, 1);

      // R6 R8 R11 readback held by ready low
      ready_mode = 2;
      base = cap_idx;
      bus_wr(A_LEN, 16);
      bus_wr(A_START, 100);
      bus_wr(A_LAUNCH, 32'd1);
      repeat (3) @(negedge clk);
      check("R6 cp_rd in readback", {30'd0, cp_en, cp_rd}, 32'd3);
      bus_wr(A_LEN, 8);
      bus_wr(A_START, 0);
      bus_wr(A_LAUNCH, 32'd0);        // R8: ignored
      bus_wr(12'(300 * 4), 32'h1234_5678); // R11: ignored
      ready_mode = 0;
      wait_done("R6 readback completes");
      for (int i = 0; i < 4; i++) begin
         mdl[100+i] = 32'hCAFE_0000 + base + i;
         bus_rd(12'((100 + i) * 4), d);
         check("R6 captured word", d, mdl[100+i]);
      end
      bus_rd(12'(104 * 4), d);  check("R6 word past end untouched", d, mdl[104]);
      bus_rd(12'(300 * 4), d);  check("R11 busy write ignored", d, mdl[300]);
      check("R8 no configure words", exp_q.size(), 0);

      // R9 out of range and zero length
      en0 = en_cycles;
      bus_wr(A_LEN, 8);
      bus_wr(A_START, 511);
      bus_wr(A_LAUNCH, 32'd0);
      bus_rd(A_STATUS, d);  check("R9 busy during check", {31'd0, d[0]}, 32'd0);
      bus_rd(A_STATUS, d);  check("R9 done after reject", {31'd0, d[0]}, 32'd1);
      bus_wr(A_LEN, 3);
      bus_wr(A_START, 0);
      bus_wr(A_LAUNCH, 32'd1);
      @(negedge clk);
      bus_rd(A_STATUS, d);  check("R9 zero length done", {31'd0, d[0]}, 32'd1);
      check("R9 no port enable", en_cycles, en0);

      // R10 abort
      ready_mode = 2;
      bus_wr(A_LEN, 64);
      bus_wr(A_START, 0);
      bus_wr(A_LAUNCH, 32'd1);
      @(negedge clk);
      check("R10 running before abort", {31'd0, cp_en}, 32'd1);
      bus_wr(A_STATUS, 32'h0000_FEFE);
      check("R10 enable dropped", {31'd0, cp_en}, 32'd0);
      bus_rd(A_STATUS, d);  check("R10 done after abort", {31'd0, d[0]}, 32'd1);
      ready_mode = 0;
      configure(0, 4, 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule